// File: doc/BRIEF.md
# Sync-Relative Clamp Pulse Generator

This block produces one DC-restore gate pulse per video line for a video front end. Each line is timed from the high-to-low transition of the active-low horizontal sync input. A 10-bit line counter starts at zero one clock after that transition and then advances once per pixel clock. It stops at its top value, 1023, if no further sync arrives.

Two gates are derived from the count. Both share one programmable start position, and each has its own programmable end position. The internal gate feeds the on-chip restore logic. The external gate drives the clamp-gate input of the A/D converter. All three positions are 10-bit values, loaded through a byte-wide write port: each value is split into a 2-bit upper field and an 8-bit lower byte at separate addresses.

Written values sit in holding registers. They are copied into the working set only at the next detected sync edge, so a gate already in progress always finishes with the positions it started with.

Top module: `clamp_pulse_gen`

## Requirements
- R1: After reset both gates are low, all three positions are zero, and no gate appears before the first detected sync edge. With zero positions, a line produces no gate.
- R2: A sync edge is a clock edge at which `hsync_n` samples 0 after sampling 1 at the previous edge. In the cycle after that edge the line count is 0, so a start of 0 with an end of 1 gives a one-cycle gate in exactly that cycle.
- R3: The line count advances by one per clock and stays at 1023 when no new sync edge arrives; it never wraps back into the gate window.
- R4: `clamp_int` is high exactly in the cycles where start ≤ count < internal end.
- R5: `clamp_ext` is high exactly in the cycles where start ≤ count < external end, independently of the internal end.
- R6: When an end position is less than or equal to the start position, the matching gate stays low for the whole line.
- R7: The write map, relative to parameter BASE_ADDR (default 13), is: +0 start upper, +1 start lower, +2 internal end upper, +3 internal end lower, +4 external end upper, +5 external end lower. An upper write takes only data bits [1:0] and ignores bits [7:2]. A write to any other address has no effect.
- R8: A written position takes effect only at the next sync edge. A gate in progress is not changed by a write.
- R9: A sync edge that arrives in the middle of a line restarts the count at 0, even while a gate is high.
- R10: Holding `hsync_n` low causes no further restarts; only a new high-to-low transition restarts the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | Active-low horizontal sync, already filtered |
| reg_wr | input | 1 | Write strobe for the position registers |
| reg_addr | input | 8 | Write address |
| reg_wdata | input | 8 | Write data byte |
| clamp_int | output | 1 | Internal DC-restore gate |
| clamp_ext | output | 1 | Clamp gate for the A/D converter |

## Verification
The hardest case to reach from the ports is the saturated state of the count. The bench drives a single line longer than 2048 clocks with a window placed just below 1023. If the count wrapped instead of holding, a second gate would appear, and the bench would see it.

The deferred update is the other difficult case. The bench writes new positions while a gate is high, checks that the current gate ends at its old position, and checks that the next line uses the new values. Every cycle of every line is compared against a reference model built from the requirements. That model is fed by the same driver task that creates the stimulus.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

    // Line timer states
    typedef enum logic [1:0] {
        ST_WAIT_SYNC = 2'd0,
        ST_COUNT     = 2'd1,
        ST_SATURATED = 2'd2
    } line_state_e;

    // Number of programmable positions: start, internal end, external end
    localparam int NUM_POS = 3;
    localparam int POS_START   = 0;
    localparam int POS_INT_END = 1;
    localparam int POS_EXT_END = 2;

endpackage

// File: rtl/clamp_regs.sv
module clamp_regs #(
    parameter int CNT_W     = 10,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int BASE_ADDR = 13
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         wr_en,
    input  logic [ADDR_W-1:0]                            wr_addr,
    input  logic [DATA_W-1:0]                            wr_data,
    input  logic                                         apply,
    output logic [clamp_pkg::NUM_POS-1:0][CNT_W-1:0]     act_pos
);
    localparam int HI_W = CNT_W - DATA_W;

    for (genvar v = 0; v < clamp_pkg::NUM_POS; v++) begin : g_pos
        localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR + 2 * v);
        localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE_ADDR + 2 * v + 1);

        logic [CNT_W-1:0] hold_q;
        logic [CNT_W-1:0] work_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_q <= '0;
                work_q <= '0;
            end else begin
                // the working copy takes the holding value seen before this edge
                if (apply) begin
                    work_q <= hold_q;
                end
                if (wr_en && (wr_addr == HI_ADDR)) begin
                    hold_q[CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
                end
                if (wr_en && (wr_addr == LO_ADDR)) begin
                    hold_q[DATA_W-1:0] <= wr_data;
                end
            end
        end

        assign act_pos[v] = work_q;
    end

endmodule

// File: rtl/clamp_line_timer.sv
module clamp_line_timer #(
    parameter int CNT_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hsync_n,
    output logic                    line_start,
    output logic                    running,
    output logic [CNT_W-1:0]        count,
    output clamp_pkg::line_state_e  state
);
    import clamp_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_BEFORE = CNT_MAX - CNT_W'(1);

    logic        hs_q;
    line_state_e state_nxt;

    // previous sync sample, for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
        end else begin
            hs_q <= hsync_n;
        end
    end

    assign line_start = hs_q & ~hsync_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT_SYNC;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WAIT_SYNC: begin
                if (line_start) state_nxt = ST_COUNT;
            end
            ST_COUNT: begin
                if (line_start)                state_nxt = ST_COUNT;
                else if (count == CNT_BEFORE)  state_nxt = ST_SATURATED;
            end
            ST_SATURATED: begin
                if (line_start) state_nxt = ST_COUNT;
            end
            default: state_nxt = ST_WAIT_SYNC;
        endcase
    end

    // line counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (line_start) begin
            count <= '0;
        end else if (state == ST_COUNT) begin
            count <= count + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_WAIT_SYNC: running = 1'b0;
            ST_COUNT:     running = 1'b1;
            ST_SATURATED: running = 1'b1;
            default:      running = 1'b0;
        endcase
    end

endmodule

// File: rtl/clamp_window.sv
module clamp_window #(
    parameter int CNT_W = 10
) (
    input  logic             running,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] pos_lo,
    input  logic [CNT_W-1:0] pos_hi,
    output logic             gate
);
    always_comb begin
        gate = running && (count >= pos_lo) && (count < pos_hi);
    end
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen #(
    parameter int CNT_W     = 10,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int BASE_ADDR = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              clamp_int,
    output logic              clamp_ext
);
    import clamp_pkg::*;

    localparam int NUM_GATES = 2;

    logic                               line_start;
    logic                               running;
    logic [CNT_W-1:0]                   line_count;
    line_state_e                        line_state;
    logic [NUM_POS-1:0][CNT_W-1:0]      act_pos;
    logic [NUM_GATES-1:0][CNT_W-1:0]    gate_end;
    logic [NUM_GATES-1:0]               gate;

    clamp_regs #(
        .CNT_W    (CNT_W),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .wr_addr(reg_addr),
        .wr_data(reg_wdata),
        .apply  (line_start),
        .act_pos(act_pos)
    );

    clamp_line_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync_n   (hsync_n),
        .line_start(line_start),
        .running   (running),
        .count     (line_count),
        .state     (line_state)
    );

    assign gate_end[0] = act_pos[POS_INT_END];
    assign gate_end[1] = act_pos[POS_EXT_END];

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        clamp_window #(
            .CNT_W(CNT_W)
        ) u_win (
            .running(running),
            .count  (line_count),
            .pos_lo (act_pos[POS_START]),
            .pos_hi (gate_end[g]),
            .gate   (gate[g])
        );
    end

    assign clamp_int = gate[0];
    assign clamp_ext = gate[1];

endmodule

// File: rtl/clamp_pulse_chk.sv
module clamp_pulse_chk #(
    parameter int CNT_W = 10
) (
    input logic                                      clk,
    input logic                                      rst_n,
    input logic                                      line_start,
    input logic [CNT_W-1:0]                          line_count,
    input clamp_pkg::line_state_e                    line_state,
    input logic [clamp_pkg::NUM_POS-1:0][CNT_W-1:0]  act_pos,
    input logic                                      clamp_int,
    input logic                                      clamp_ext
);
    import clamp_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R1: gates are low right after any reset cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!clamp_int && !clamp_ext));

    // R1: nothing is produced before the first sync edge
    a_r1_no_gate_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == ST_WAIT_SYNC) |-> (!clamp_int && !clamp_ext));

    // R2: the count restarts at zero after a sync edge
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (line_count == '0 && line_state == ST_COUNT));

    // R3: one step per clock while counting
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == ST_COUNT && !line_start) |=> (line_count == $past(line_count) + CNT_W'(1)));

    // R3: saturation holds until a new sync edge
    a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == ST_SATURATED && !line_start) |=> (line_state == ST_SATURATED && line_count == CNT_MAX));

    // R6: a gate only exists with a non-empty window
    a_r6_int_window: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_int |-> (act_pos[POS_START] < act_pos[POS_INT_END]));

    a_r6_ext_window: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_ext |-> (act_pos[POS_START] < act_pos[POS_EXT_END]));

    // R8: working positions only change at a sync edge
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(act_pos));

endmodule

bind clamp_pulse_gen clamp_pulse_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .line_count(line_count),
    .line_state(line_state),
    .act_pos   (act_pos),
    .clamp_int (clamp_int),
    .clamp_ext (clamp_ext)
);

// File: tb/clamp_pulse_gen_tb.sv
`timescale 1ns/1ps
module clamp_pulse_gen_tb;

    localparam int BASE = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_n = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       clamp_int;
    logic       clamp_ext;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    clamp_pulse_gen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync_n  (hsync_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .clamp_int(clamp_int),
        .clamp_ext(clamp_ext)
    );

    typedef struct {
        bit    exp_int;
        bit    exp_ext;
        string tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    string     cur_tag = "R1";

    // reference model state, derived from the requirements
    bit        m_hsq = 1'b0;
    bit        m_run = 1'b0;
    int        m_cnt = 0;
    int        m_hold[3] = '{0, 0, 0};
    int        m_work[3] = '{0, 0, 0};

    task automatic check(input string tag, input bit act, input bit exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // driver: apply one cycle of stimulus, advance the model, push the expectation
    task automatic cyc(input bit hs, input bit we = 1'b0, input int a = 0, input int d = 0);
        exp_item_t it;
        bit fall;
        @(negedge clk);
        hsync_n   = hs;
        reg_wr    = we;
        reg_addr  = 8'(a);
        reg_wdata = 8'(d);
        @(posedge clk);
        fall  = m_hsq && !hs;
        m_hsq = hs;
        if (fall) begin
            for (int i = 0; i < 3; i++) m_work[i] = m_hold[i];
            m_cnt = 0;
            m_run = 1'b1;
        end else if (m_run && m_cnt < 1023) begin
            m_cnt++;
        end
        if (we) begin
            for (int i = 0; i < 3; i++) begin
                if (a == BASE + 2 * i)     m_hold[i] = (m_hold[i] & 8'hFF) | ((d & 3) << 8);
                if (a == BASE + 2 * i + 1) m_hold[i] = (m_hold[i] & 10'h300) | (d & 8'hFF);
            end
        end
        it.exp_int = m_run && (m_cnt >= m_work[0]) && (m_cnt < m_work[1]);
        it.exp_ext = m_run && (m_cnt >= m_work[0]) && (m_cnt < m_work[2]);
        it.tag     = cur_tag;
        exp_q.push_back(it);
    endtask

    // monitor: compare each cycle after the outputs settle
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_item_t it;
                it = exp_q.pop_front();
                check(it.tag, clamp_int, it.exp_int, "clamp_int");
                check(it.tag, clamp_ext, it.exp_ext, "clamp_ext");
            end
        end
    end

    task automatic wr(input int a, input int d);
        cyc(1'b1, 1'b1, a, d);
    endtask

    task automatic set_pos(input int idx, input int val);
        wr(BASE + 2 * idx, (val >> 8) & 3);
        wr(BASE + 2 * idx + 1, val & 8'hFF);
    endtask

    task automatic line(input int len);
        repeat (8) cyc(1'b0);
        repeat (len - 8) cyc(1'b1);
    endtask

    initial begin
        // R1: outputs during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", clamp_int, 1'b0, "clamp_int in reset");
        check("R1", clamp_ext, 1'b0, "clamp_ext in reset");
        rst_n = 1'b1;

        // R1: idle, then a line with zero positions
        cur_tag = "R1";
        repeat (10) cyc(1'b1);
        line(50);

        // R7: address map, junk upper bits, stray addresses
        cur_tag = "R7";
        wr(BASE + 0, 8'hFC);
        wr(BASE + 1, 5);
        wr(BASE + 2, 8'h00);
        wr(BASE + 3, 20);
        wr(BASE + 4, 8'hFD);
        wr(BASE + 5, 5);
        wr(BASE - 1, 8'hFF);
        wr(BASE + 6, 8'hFF);
        line(300);

        // R4 R5: steady lines with separate ends
        cur_tag = "R4 R5";
        line(300);

        // R2: a one-cycle gate in the first counted cycle
        cur_tag = "R2";
        set_pos(0, 0);
        set_pos(1, 1);
        set_pos(2, 2);
        line(20);
        line(20);

        // R8: write during a gate, deferred to the next line
        cur_tag = "R8";
        set_pos(0, 5);
        set_pos(1, 30);
        set_pos(2, 30);
        line(40);
        repeat (8) cyc(1'b0);
        repeat (4) cyc(1'b1);
        set_pos(0, 40);
        set_pos(1, 60);
        repeat (80) cyc(1'b1);
        line(100);

        // R6: end equal to and below start
        cur_tag = "R6";
        set_pos(1, 40);
        set_pos(2, 10);
        line(200);
        line(60);

        // R9: sync edge while the gate is high
        cur_tag = "R9";
        set_pos(0, 2);
        set_pos(1, 100);
        set_pos(2, 100);
        line(60);
        line(50);
        line(200);

        // R10: sync held low, no further restarts
        cur_tag = "R10";
        set_pos(0, 300);
        set_pos(1, 350);
        set_pos(2, 320);
        line(20);
        repeat (400) cyc(1'b0);
        repeat (50) cyc(1'b1);

        // R3: saturation, no wrap back into the window
        cur_tag = "R3";
        set_pos(0, 1000);
        set_pos(1, 1023);
        set_pos(2, 1023);
        line(20);
        line(2200);

        repeat (3) @(posedge clk);
        #3;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule